// File: doc/BRIEF.md
# Page Entry Check and Update

This block serves one address translation at a time. Given the memory address of a 64-bit page entry, a 12-bit offset into the page, the kind of access and the privilege of the requester, it reads the entry through a simple memory port. It checks the access against the entry's presence, privilege, write and execute bits. It then reports either a fault with a cause code or the physical address, formed from the entry's 40-bit frame number and the page offset.

When an access is allowed and the entry's accessed bit is clear, the block sets that bit in the stored entry. On a write it also sets the dirty bit. The update is a read-modify-write made under a lock. The lock stays asserted on the memory port from the read until the write-back completes, so no other agent can change the entry in between. When the status bits are already set, or when the access faults, nothing is written back.

Top module: `page_entry_checker`

## Requirements
- R1: When entry bit 0 (present) is 0, the result is fault cause 1 whatever the other entry bits, access kind and privilege are.
- R2: A present entry with bit 2 (user-allowed) equal to 0 gives cause 2 for a user access (req_user=1). A supervisor access (req_user=0) is not restricted by bit 2.
- R3: A write access (req_kind=1) to a present, privilege-permitted entry with bit 1 (writable) equal to 0 gives cause 3. Reads are not restricted by bit 1.
- R4: An execute access (req_kind=2) to a present, privilege-permitted entry with bit 63 (no-execute) equal to 1 gives cause 4. req_kind=3 behaves as a read.
- R5: Fault checks apply in priority order: cause 1 before 2, 2 before 3, 3 before 4. Cause 0 means no fault, and fault is 1 exactly when the cause is non-zero.
- R6: On an allowed access, phys_addr equals entry bits 51..12 placed above the 12-bit offset. On a fault, phys_addr is 0.
- R7: On an allowed access the stored entry ends with bit 5 (accessed) set. On an allowed write it also ends with bit 6 (dirty) set.
- R8: No write-back happens when the access faults, or when the bits it would set are already set.
- R9: A write-back changes no entry bit other than bits 5 and 6. This covers the frame, the permission bits and the software-owned bits 9..11 and 52..58.
- R10: mem_lock is asserted whenever mem_req is. It stays asserted without a break from the read through the write-back.
- R11: Each accepted request produces exactly one single-cycle done pulse. A request presented while the block is busy is ignored.
- R12: After reset, done, mem_req and mem_lock are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a check (accepted only when idle) |
| req_entry_addr | input | ADDR_W | Memory address of the page entry |
| req_offset | input | OFF_W | Offset within the 4 KB page |
| req_kind | input | 2 | 0 read, 1 write, 2 execute, 3 read |
| req_user | input | 1 | 1 user privilege, 0 supervisor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_lock | output | 1 | Exclusive hold on the entry |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 64 | Entry written back |
| mem_rdata | input | 64 | Entry read, valid with mem_ack |
| mem_ack | input | 1 | Memory completes the current access |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Access faulted |
| fault_cause | output | 3 | 0 none, 1 absent, 2 privilege, 3 write-protect, 4 no-execute |
| phys_addr | output | PA_W | Translated physical address |

## Verification
On every cycle the assertions check four things. A write-back only follows an allowed access. The written entry carries the accessed bit and differs from the read entry in bits 5 and 6 only. The lock is held across the read-to-write window. Done never lasts two cycles. The scenarios are needed for the rest. Only they can show the cause priority across combined faulty bits, the frame-and-offset join, the absence of a write-back when status bits are already set, and that a request arriving mid-check is dropped. They run these against memory latencies of zero to three cycles.

// File: rtl/pgent_pkg.sv
// Shared definitions for the page entry checker.
// Assumes a 64-bit entry with fixed bit positions for the checked fields.
package pgent_pkg;
    localparam int ENTRY_W    = 64;
    localparam int BIT_PRES   = 0;
    localparam int BIT_WRITE  = 1;
    localparam int BIT_USER   = 2;
    localparam int BIT_ACC    = 5;
    localparam int BIT_DIRTY  = 6;
    localparam int BIT_NOEXEC = 63;
    localparam int FRAME_LSB  = 12;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_READ2 = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_ABSENT = 3'd1,
        CAUSE_PRIV   = 3'd2,
        CAUSE_WPROT  = 3'd3,
        CAUSE_NOEXEC = 3'd4
    } cause_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_READ, SQ_CHECK, SQ_WBACK, SQ_DONE
    } seq_state_e;
endpackage

// File: rtl/pgent_perm_eval.sv
// Permission evaluator: a combinational check of one page entry against an
// access kind and a privilege. Produces the fault cause, the entry with its
// status bits set, and whether a write-back is needed.
// Assumes the entry input is stable while its results are used.
module pgent_perm_eval
    import pgent_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    input  logic [1:0]         kind,
    input  logic               user,
    output cause_e             cause,
    output logic [ENTRY_W-1:0] upd_entry,
    output logic               need_wb
);
    logic               is_write;
    logic               is_exec;
    logic [ENTRY_W-1:0] set_mask;

    // Decode the access kind; code 3 falls back to a read.
    always_comb begin
        is_write = (kind == ACC_WRITE);
        is_exec  = (kind == ACC_EXEC);
    end

    // Priority fault check: absent, privilege, write-protect, no-execute.
    always_comb begin
        cause = CAUSE_NONE;
        if (!entry[BIT_PRES])
            cause = CAUSE_ABSENT;
        else if (user && !entry[BIT_USER])
            cause = CAUSE_PRIV;
        else if (is_write && !entry[BIT_WRITE])
            cause = CAUSE_WPROT;
        else if (is_exec && entry[BIT_NOEXEC])
            cause = CAUSE_NOEXEC;
    end

    // Status bits to set: accessed always, dirty on writes.
    always_comb begin
        set_mask            = '0;
        set_mask[BIT_ACC]   = 1'b1;
        set_mask[BIT_DIRTY] = is_write;
        upd_entry = entry | set_mask;
        need_wb   = (cause == CAUSE_NONE) && ((entry & set_mask) != set_mask);
    end
endmodule

// File: rtl/pgent_addr_join.sv
// Address joiner: places the frame number above the page offset.
// Assumes both fields are already aligned to bit 0.
module pgent_addr_join #(
    parameter int FRAME_W = 40,
    parameter int OFF_W   = 12,
    localparam int PA_W   = FRAME_W + OFF_W
) (
    input  logic [FRAME_W-1:0] frame,
    input  logic [OFF_W-1:0]   offset,
    input  logic               blank,
    output logic [PA_W-1:0]    phys
);
    // Join the fields; a faulted access gives zero.
    always_comb begin
        phys = blank ? '0 : {frame, offset};
    end
endmodule

// File: rtl/pgent_seq.sv
// Sequencer for one locked read-check-write transaction on the memory port.
// Assumes mem_ack completes the current access and may come on the first
// cycle of the request or any later one.
module pgent_seq
    import pgent_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic mem_ack,
    input  logic need_wb,
    output logic mem_req,
    output logic mem_we,
    output logic mem_lock,
    output logic idle,
    output logic rd_done,
    output logic in_check,
    output logic done
);
    seq_state_e st, st_nx;

    // Next-state choice for the transaction.
    always_comb begin
        st_nx = st;
        unique case (st)
            SQ_IDLE:  if (start) st_nx = SQ_READ;
            SQ_READ:  if (mem_ack) st_nx = SQ_CHECK;
            SQ_CHECK: st_nx = need_wb ? SQ_WBACK : SQ_DONE;
            SQ_WBACK: if (mem_ack) st_nx = SQ_DONE;
            SQ_DONE:  st_nx = SQ_IDLE;
            default:  st_nx = SQ_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SQ_IDLE;
        else        st <= st_nx;
    end

    // Port and status decode from the current state.
    always_comb begin
        mem_req  = (st == SQ_READ) || (st == SQ_WBACK);
        mem_we   = (st == SQ_WBACK);
        mem_lock = (st == SQ_READ) || (st == SQ_CHECK) || (st == SQ_WBACK);
        idle     = (st == SQ_IDLE);
        rd_done  = (st == SQ_READ) && mem_ack;
        in_check = (st == SQ_CHECK);
        done     = (st == SQ_DONE);
    end

    // R10
    lock_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> $past(mem_lock));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/page_entry_checker.sv
// Page entry checker top: accepts one translation request, reads the page
// entry under lock, checks permissions, writes back accessed/dirty bits
// when needed and reports a fault cause or the physical address.
// Assumes a single outstanding request; new requests while busy are dropped.
module page_entry_checker
    import pgent_pkg::*;
#(
    parameter int ADDR_W  = 48,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 40,
    localparam int PA_W   = FRAME_W + OFF_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_entry_addr,
    input  logic [OFF_W-1:0]    req_offset,
    input  logic [1:0]          req_kind,
    input  logic                req_user,
    output logic                mem_req,
    output logic                mem_we,
    output logic                mem_lock,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [ENTRY_W-1:0]  mem_wdata,
    input  logic [ENTRY_W-1:0]  mem_rdata,
    input  logic                mem_ack,
    output logic                done,
    output logic                fault,
    output logic [2:0]          fault_cause,
    output logic [PA_W-1:0]     phys_addr
);
    logic [ADDR_W-1:0]  addr_q;
    logic [OFF_W-1:0]   off_q;
    logic [1:0]         kind_q;
    logic               user_q;
    logic [ENTRY_W-1:0] entry_q;
    logic               fault_q;
    logic [2:0]         cause_q;
    logic [PA_W-1:0]    pa_q;

    cause_e             ev_cause;
    logic [ENTRY_W-1:0] ev_upd;
    logic               ev_need_wb;
    logic               idle, rd_done, in_check;
    logic [PA_W-1:0]    joined;

    pgent_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (req_valid),
        .mem_ack  (mem_ack),
        .need_wb  (ev_need_wb),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_lock (mem_lock),
        .idle     (idle),
        .rd_done  (rd_done),
        .in_check (in_check),
        .done     (done)
    );

    pgent_perm_eval u_eval (
        .entry     (entry_q),
        .kind      (kind_q),
        .user      (user_q),
        .cause     (ev_cause),
        .upd_entry (ev_upd),
        .need_wb   (ev_need_wb)
    );

    pgent_addr_join #(.FRAME_W(FRAME_W), .OFF_W(OFF_W)) u_join (
        .frame  (entry_q[FRAME_LSB +: FRAME_W]),
        .offset (off_q),
        .blank  (ev_cause != CAUSE_NONE),
        .phys   (joined)
    );

    // Capture the request when the sequencer is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            off_q  <= '0;
            kind_q <= '0;
            user_q <= 1'b0;
        end else if (idle && req_valid) begin
            addr_q <= req_entry_addr;
            off_q  <= req_offset;
            kind_q <= req_kind;
            user_q <= req_user;
        end
    end

    // Hold the entry returned by the locked read.
    always_ff @(posedge clk) begin
        if (!rst_n)       entry_q <= '0;
        else if (rd_done) entry_q <= mem_rdata;
    end

    // Register the check result once the entry is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
            cause_q <= CAUSE_NONE;
            pa_q    <= '0;
        end else if (in_check) begin
            fault_q <= (ev_cause != CAUSE_NONE);
            cause_q <= ev_cause;
            pa_q    <= joined;
        end
    end

    // Drive the result and memory data outputs.
    always_comb begin
        mem_addr    = addr_q;
        mem_wdata   = ev_upd;
        fault       = fault_q;
        fault_cause = cause_q;
        phys_addr   = pa_q;
    end

    // R8
    wb_only_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (ev_cause == CAUSE_NONE));

    // R9
    wb_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |->
        ((mem_wdata ^ entry_q) & ~((64'd1 << BIT_ACC) | (64'd1 << BIT_DIRTY))) == 64'd0);

    // R7
    wb_sets_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[BIT_ACC]);

    // R5
    fault_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fault == (fault_cause != 3'd0)));
endmodule

// File: tb/page_entry_checker_test.sv
module page_entry_checker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [47:0] req_entry_addr = '0;
    logic [11:0] req_offset = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic        mem_req, mem_we, mem_lock;
    logic [47:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        done, fault;
    logic [2:0]  fault_cause;
    logic [51:0] phys_addr;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int mem_lat = 0;
    int wcnt = 0;
    int wr_count = 0;
    int done_count = 0;
    bit locked_since_read = 0;
    bit expect_wb = 0;
    logic [63:0] exp_wdata = '0;
    logic [63:0] mem [longint];

    always #2.5 clk = ~clk;

    page_entry_checker uut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural memory with latency, plus per-clock port rules (R10, R9, R11).
    always @(negedge clk) begin
        cycles++;
        if (done) done_count++;
        mem_ack = 1'b0;
        if (rst_n) begin
            chk(!mem_req || mem_lock, "R10 req without lock", {63'd0, mem_lock}, 64'd1);
            if (!mem_lock) locked_since_read = 0;
            if (mem_req) begin
                if (wcnt >= mem_lat) begin
                    mem_ack = 1'b1;
                    wcnt = 0;
                    if (mem_we) begin
                        wr_count++;
                        chk(expect_wb, "R8 unexpected write-back", 64'd1, 64'd0);
                        chk(locked_since_read, "R10 lock broken before write", 64'd0, 64'd1);
                        chk(mem_wdata == exp_wdata, "R9 write-back data", mem_wdata, exp_wdata);
                        mem[longint'(mem_addr)] = mem_wdata;
                    end else begin
                        mem_rdata = mem.exists(longint'(mem_addr)) ? mem[longint'(mem_addr)] : 64'd0;
                        locked_since_read = 1;
                    end
                end else wcnt++;
            end else wcnt = 0;
        end
    end

    // Reference model of the check.
    function automatic void model(input logic [63:0] e, input int kind, input bit user,
                                  output int cause, output logic [63:0] ne, output bit wb);
        bit wr = (kind == 1);
        bit ex = (kind == 2);
        cause = 0;
        if (e[0] == 0) cause = 1;
        else if (user && e[2] == 0) cause = 2;
        else if (wr && e[1] == 0) cause = 3;
        else if (ex && e[63] == 1) cause = 4;
        ne = e;
        wb = 0;
        if (cause == 0) begin
            ne[5] = 1;
            if (wr) ne[6] = 1;
            wb = (ne != e);
        end
    endfunction

    task automatic run(input string tag, input logic [47:0] a, input logic [63:0] e,
                       input int kind, input bit user, input logic [11:0] off, input bit poke);
        int cause;
        logic [63:0] ne;
        bit wb;
        int w0, d0, waited;
        logic [51:0] exp_pa;
        model(e, kind, user, cause, ne, wb);
        mem[longint'(a)] = e;
        expect_wb = wb;
        exp_wdata = ne;
        exp_pa = (cause == 0) ? {e[51:12], off} : 52'd0;
        w0 = wr_count;
        d0 = done_count;
        @(negedge clk);
        req_valid = 1; req_entry_addr = a; req_kind = kind[1:0]; req_user = user; req_offset = off;
        @(negedge clk);
        if (poke) begin
            req_kind = 2'd1; req_user = 1; req_offset = ~off; req_entry_addr = a + 48'd8;
            @(negedge clk);
        end
        req_valid = 0;
        waited = 0;
        while (!done && waited < 60) begin @(negedge clk); waited++; end
        chk(done, {tag, " R11 done seen"}, {63'd0, done}, 64'd1);
        chk(fault_cause == cause[2:0], {tag, " cause"}, {61'd0, fault_cause}, cause);
        chk(fault == (cause != 0), {tag, " R5 fault flag"}, {63'd0, fault}, {63'd0, cause != 0});
        chk(phys_addr == exp_pa, {tag, " R6 phys"}, {12'd0, phys_addr}, {12'd0, exp_pa});
        @(negedge clk);
        chk(!done, {tag, " R11 single pulse"}, {63'd0, done}, 64'd0);
        repeat (4) @(negedge clk);
        chk(done_count == d0 + 1, {tag, " R11 one done"}, done_count, d0 + 1);
        chk(wr_count == w0 + (wb ? 1 : 0), {tag, " R8 write count"}, wr_count - w0, wb ? 1 : 0);
        chk(mem[longint'(a)] == ne, {tag, " R7 stored entry"}, mem[longint'(a)], ne);
        expect_wb = 0;
    endtask

    localparam logic [63:0] FR = 64'h0000_ABCD_E123_4000;   // frame field only

    initial begin
        repeat (3) @(negedge clk);
        chk(!done && !mem_req && !mem_lock, "R12 reset outputs", {61'd0, done, mem_req, mem_lock}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        chk(!done && !mem_req && !mem_lock, "R12 idle after reset", {61'd0, done, mem_req, mem_lock}, 64'd0);

        mem_lat = 0;
        run("R1 absent", 48'h100, 64'hFFFF_FFFF_FFFF_FFFE, 1, 1, 12'h123, 0);
        run("R1 absent exec", 48'h108, FR | 64'h6, 2, 0, 12'h0, 0);
        mem_lat = 1;
        run("R2 user priv", 48'h110, FR | 64'h3, 0, 1, 12'h456, 0);
        run("R2 supervisor ok", 48'h118, FR | 64'h1, 0, 0, 12'hABC, 0);
        run("R3 write protect", 48'h120, FR | 64'h5, 1, 1, 12'h001, 0);
        run("R3 read of ro", 48'h128, FR | 64'h5, 0, 1, 12'hFFF, 0);
        mem_lat = 3;
        run("R4 noexec", 48'h130, FR | 64'h8000_0000_0000_0007, 2, 1, 12'h010, 0);
        run("R4 kind3 as read", 48'h138, FR | 64'h8000_0000_0000_0005, 3, 1, 12'h020, 0);
        run("R5 priv over wprot", 48'h140, FR | 64'h8000_0000_0000_0001, 1, 1, 12'h0, 0);
        run("R5 wprot sup", 48'h148, FR | 64'h8000_0000_0000_0001, 1, 0, 12'h0, 0);
        run("R5 noexec sup", 48'h150, FR | 64'h8000_0000_0000_0001, 2, 0, 12'h0, 0);
        mem_lat = 0;
        run("R7 write sets A D", 48'h158, FR | 64'h07F0_0000_0000_0E07, 1, 1, 12'h777, 0);
        run("R9 exec sets A only", 48'h160, FR | 64'h0450_0000_0000_0A17, 2, 1, 12'h5A5, 0);
        mem_lat = 2;
        run("R8 read A set", 48'h168, FR | 64'h27, 0, 1, 12'h3, 0);
        run("R7 write A set D clr", 48'h170, FR | 64'h27, 1, 1, 12'h4, 0);
        run("R8 write A D set", 48'h178, FR | 64'h67, 1, 0, 12'h5, 0);
        run("R11 busy poke", 48'h180, FR | 64'h3, 0, 0, 12'h9, 1);
        chk(mem[longint'(48'h188)] === 64'hx || !mem.exists(longint'(48'h188)),
            "R11 poke address untouched", 64'd0, 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog ends a hung run as a failure.
    initial begin
        wait (cycles > 20000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<20000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule